// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block runs one request descriptor for a single DMA channel. The descriptor has already been fetched from the request ring and decoded into fields. The block accepts it only while idle. It then works through a fixed series of steps. First it optionally waits on a presync semaphore condition. Next it optionally starts a transfer on an external data mover and waits for that mover to finish. After that it clears every postsync semaphore condition that the descriptor enables. Last, it optionally issues a doorbell write of 8, 16 or 32 bits with matching byte strobes.

When the request ends, the block pulses `done` together with the descriptor's force-interrupt flag, so the pointer register bank can advance. It also writes a response entry if the descriptor asks for one. A descriptor that is malformed in one of three ways performs none of the steps. Its response carries a non-zero completion code instead. The sequence-ID field and the reserved command bits are accepted and ignored.

Top module: `dma_req_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A descriptor is taken on a clock edge where `req_valid` and `req_ready` are both high. Descriptor inputs and `req_valid` have no effect while the block is busy.
- R2: The command byte is decoded by bit position: bit 7 forces an interrupt, bit 4 requests a response entry, bit 3 selects bulk (1) or linked-list (0), and bits 1:0 give the transfer type (0 none, 1 to device, 2 from device, 3 illegal). Bits 6:5, bit 2 and the sequence-ID field have no effect. `dma_dir` and `dma_bulk` carry the decoded type and mode.
- R3: For a legal request, actions occur in this order: presync grant, transfer start, postsync grants, doorbell write, then `done`. At most one of these is active in any cycle.
- R4: `sem_req` stays high with a stable `sem_sel` until `sem_gnt`. `sem_sel` is 0 for the presync condition and k+1 for postsync condition k. The presync condition is requested only when its enable is set. Postsync conditions are requested one grant each, in ascending k, only for the set bits of `d_post_en`.
- R5: For transfer type 0 no transfer starts. For types 1 and 2, `dma_start` pulses for one cycle with the descriptor's source, destination and 32-bit length. The block then waits for `dma_done`.
- R6: Doorbell attribute bit 7 enables the doorbell write. Bits 1:0 give its width: 0 is 32 bits, 1 is 16 bits, 2 is 8 bits, 3 is reserved.
- R7: A doorbell write pulses `db_we` for one cycle with the descriptor's address. For 32 bits, `db_be` is 4'hF and the data passes unchanged. For 16 bits, `db_be` is 4'h3 shifted by address bit 1 times two, and the data is the low half replicated twice. For 8 bits, `db_be` is 4'h1 shifted by address bits 1:0, and the data is the low byte replicated four times.
- R8: The completion code is 1 for transfer type 3. Otherwise, with the doorbell enabled, it is 2 for width 3. Otherwise, with the doorbell enabled, it is 3 for an address not aligned to the width: 32-bit needs bits 1:0 zero, 16-bit needs bit 0 zero. In all other cases it is 0. A non-zero code ends the request with no semaphore request, no transfer and no doorbell write.
- R9: `rsp_we` pulses in the `done` cycle only when command bit 4 is set. It carries the 16-bit request ID and the 16-bit completion code.
- R10: `done` pulses for one cycle at the end of every accepted request. `done_irq` equals command bit 7 in that cycle. The block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor present |
| req_ready | output | 1 | Block idle, descriptor accepted |
| d_req_id | input | 16 | Request ID |
| d_seq_id | input | 8 | Sequence ID (ignored) |
| d_cmd | input | 8 | Command byte |
| d_src | input | ADDR_W | Transfer source address |
| d_dst | input | ADDR_W | Transfer destination address |
| d_len | input | 32 | Transfer length in bytes |
| d_bell_addr | input | ADDR_W | Doorbell address |
| d_bell_attr | input | 8 | Doorbell attribute byte |
| d_bell_data | input | 32 | Doorbell data |
| d_pre_en | input | 1 | Presync condition present |
| d_post_en | input | NPOST | Postsync conditions present |
| sem_req | output | 1 | Semaphore condition request |
| sem_sel | output | SEL_W | Which condition is requested |
| sem_gnt | input | 1 | Condition satisfied |
| dma_start | output | 1 | Transfer start pulse |
| dma_dir | output | 2 | Transfer type |
| dma_bulk | output | 1 | Bulk (1) or linked-list (0) |
| dma_src | output | ADDR_W | Source address |
| dma_dst | output | ADDR_W | Destination address |
| dma_len | output | 32 | Length |
| dma_done | input | 1 | Transfer finished |
| db_we | output | 1 | Doorbell write pulse |
| db_addr | output | ADDR_W | Doorbell address |
| db_wdata | output | 32 | Doorbell write data |
| db_be | output | 4 | Doorbell byte strobes |
| rsp_we | output | 1 | Response entry write |
| rsp_id | output | 16 | Response request ID |
| rsp_code | output | 16 | Completion code |
| done | output | 1 | Request finished |
| done_irq | output | 1 | Force-interrupt flag with done |

## Verification
The bench sweeps every transfer type, every doorbell width, every low address pair and both doorbell enable states. It varies presync and postsync masks, the flags and the reserved bits across that sweep. For each request it compares the logged order of grants, starts, writes and completion with the expected order.

Several faults would show up in that comparison:
- A design that let a disabled doorbell's bad width or alignment raise an error would report a false non-zero code.
- A design that checked alignment before width would report the wrong code.
- A design that forgot to suppress the transfer on an error would show an extra start.
- Wrong strobe shifts or missing data replication show up directly as bad lanes.

Descriptor inputs are scrambled while the block is busy, so a design that sampled them late would carry the wrong ID or addresses.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_TO_DEV   = 2'd1,
        XF_FROM_DEV = 2'd2,
        XF_BAD      = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        BW_32  = 2'd0,
        BW_16  = 2'd1,
        BW_8   = 2'd2,
        BW_RSV = 2'd3
    } bw_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DISP, ST_PRE, ST_XGO, ST_XWAIT, ST_POST, ST_BELL, ST_FIN
    } st_e;

    typedef struct packed {
        logic  irq;
        logic  rsp;
        logic  bulk;
        xfer_e xfer;
        logic  bell;
        bw_e   bw;
    } dcmd_t;

    typedef logic [15:0] ccode_t;

    localparam int CMD_IRQ_BIT  = 7;
    localparam int CMD_RSP_BIT  = 4;
    localparam int CMD_BULK_BIT = 3;
    localparam int ATTR_EN_BIT  = 7;

    localparam ccode_t CC_OK        = 16'd0;
    localparam ccode_t CC_BAD_XFER  = 16'd1;
    localparam ccode_t CC_BAD_WIDTH = 16'd2;
    localparam ccode_t CC_MISALIGN  = 16'd3;

    function automatic logic bell_aligned(input bw_e w, input logic [1:0] lo);
        case (w)
            BW_32:   return lo == 2'b00;
            BW_16:   return lo[0] == 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] bell_strobe(input bw_e w, input logic [1:0] lo);
        case (w)
            BW_32:   return 4'hF;
            BW_16:   return lo[1] ? 4'hC : 4'h3;
            BW_8:    return 4'h1 << lo;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] bell_lanes(input bw_e w, input logic [31:0] d);
        case (w)
            BW_16:   return {2{d[15:0]}};
            BW_8:    return {4{d[7:0]}};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dreq_decode.sv
module dreq_decode
    import dreq_pkg::*;
(
    input  logic [7:0] cmd,
    input  logic [7:0] attr,
    input  logic [1:0] addr_lo,
    output dcmd_t      dec,
    output ccode_t     code
);
    always_comb begin
        dec.irq  = cmd[CMD_IRQ_BIT];
        dec.rsp  = cmd[CMD_RSP_BIT];
        dec.bulk = cmd[CMD_BULK_BIT];
        dec.xfer = xfer_e'(cmd[1:0]);
        dec.bell = attr[ATTR_EN_BIT];
        dec.bw   = bw_e'(attr[1:0]);
        if (dec.xfer == XF_BAD)
            code = CC_BAD_XFER;
        else if (dec.bell && dec.bw == BW_RSV)
            code = CC_BAD_WIDTH;
        else if (dec.bell && !bell_aligned(dec.bw, addr_lo))
            code = CC_MISALIGN;
        else
            code = CC_OK;
    end
endmodule

// File: rtl/dreq_bell_fmt.sv
module dreq_bell_fmt
    import dreq_pkg::*;
(
    input  bw_e         bw,
    input  logic [1:0]  addr_lo,
    input  logic [31:0] data_in,
    output logic [3:0]  be,
    output logic [31:0] data_out
);
    always_comb begin
        be       = bell_strobe(bw, addr_lo);
        data_out = bell_lanes(bw, data_in);
    end
endmodule

// File: rtl/dreq_post_pick.sv
module dreq_post_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) begin
                idx    = IW'(k);
                onehot = N'(1) << k;
            end
        end
    end
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
    import dreq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NPOST  = 4,
    localparam int SEL_W = $clog2(NPOST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       d_req_id,
    input  logic [7:0]        d_seq_id,
    input  logic [7:0]        d_cmd,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  logic [31:0]       d_len,
    input  logic [ADDR_W-1:0] d_bell_addr,
    input  logic [7:0]        d_bell_attr,
    input  logic [31:0]       d_bell_data,
    input  logic              d_pre_en,
    input  logic [NPOST-1:0]  d_post_en,
    output logic              sem_req,
    output logic [SEL_W-1:0]  sem_sel,
    input  logic              sem_gnt,
    output logic              dma_start,
    output logic [1:0]        dma_dir,
    output logic              dma_bulk,
    output logic [ADDR_W-1:0] dma_src,
    output logic [ADDR_W-1:0] dma_dst,
    output logic [31:0]       dma_len,
    input  logic              dma_done,
    output logic              db_we,
    output logic [ADDR_W-1:0] db_addr,
    output logic [31:0]       db_wdata,
    output logic [3:0]        db_be,
    output logic              rsp_we,
    output logic [15:0]       rsp_id,
    output logic [15:0]       rsp_code,
    output logic              done,
    output logic              done_irq
);
    localparam int PIW = (NPOST > 1) ? $clog2(NPOST) : 1;

    st_e               state_q, state_d;
    dcmd_t             dec_in, dec_q;
    ccode_t            code_in, code_q;
    logic [15:0]       id_q;
    logic [ADDR_W-1:0] src_q, dst_q, bell_addr_q;
    logic [31:0]       len_q, bell_data_q;
    logic              pre_q;
    logic [NPOST-1:0]  post_q, post_oh;
    logic [PIW-1:0]    post_idx;
    st_e               after_pre, after_xfer, after_post;
    logic              take;

    wire unused_seq = ^d_seq_id;

    dreq_decode u_dec (
        .cmd     (d_cmd),
        .attr    (d_bell_attr),
        .addr_lo (d_bell_addr[1:0]),
        .dec     (dec_in),
        .code    (code_in)
    );

    dreq_bell_fmt u_fmt (
        .bw       (dec_q.bw),
        .addr_lo  (bell_addr_q[1:0]),
        .data_in  (bell_data_q),
        .be       (db_be),
        .data_out (db_wdata)
    );

    dreq_post_pick #(.N(NPOST)) u_pick (
        .pend   (post_q),
        .idx    (post_idx),
        .onehot (post_oh)
    );

    assign take = req_valid && (state_q == ST_IDLE);

    always_comb begin
        after_post = dec_q.bell ? ST_BELL : ST_FIN;
        after_xfer = (|post_q) ? ST_POST : after_post;
        after_pre  = (dec_q.xfer != XF_NONE) ? ST_XGO : after_xfer;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_DISP;
            ST_DISP: begin
                if (code_q != CC_OK) state_d = ST_FIN;
                else if (pre_q)      state_d = ST_PRE;
                else                 state_d = after_pre;
            end
            ST_PRE:   if (sem_gnt) state_d = after_pre;
            ST_XGO:   state_d = ST_XWAIT;
            ST_XWAIT: if (dma_done) state_d = after_xfer;
            ST_POST: begin
                if (sem_gnt && ((post_q & ~post_oh) == '0))
                    state_d = after_post;
            end
            ST_BELL:  state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            dec_q       <= '0;
            code_q      <= CC_OK;
            id_q        <= '0;
            src_q       <= '0;
            dst_q       <= '0;
            len_q       <= '0;
            bell_addr_q <= '0;
            bell_data_q <= '0;
            pre_q       <= 1'b0;
            post_q      <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                dec_q       <= dec_in;
                code_q      <= code_in;
                id_q        <= d_req_id;
                src_q       <= d_src;
                dst_q       <= d_dst;
                len_q       <= d_len;
                bell_addr_q <= d_bell_addr;
                bell_data_q <= d_bell_data;
                pre_q       <= d_pre_en;
                post_q      <= d_post_en;
            end else if (state_q == ST_POST && sem_gnt) begin
                post_q <= post_q & ~post_oh;
            end
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        sem_req   = (state_q == ST_PRE) || (state_q == ST_POST);
        sem_sel   = (state_q == ST_POST) ? SEL_W'(post_idx) + SEL_W'(1) : '0;
        dma_start = (state_q == ST_XGO);
        dma_dir   = dec_q.xfer;
        dma_bulk  = dec_q.bulk;
        dma_src   = src_q;
        dma_dst   = dst_q;
        dma_len   = len_q;
        db_we     = (state_q == ST_BELL);
        db_addr   = bell_addr_q;
        done      = (state_q == ST_FIN);
        done_irq  = done && dec_q.irq;
        rsp_we    = done && dec_q.rsp;
        rsp_id    = id_q;
        rsp_code  = code_q;
    end

endmodule

// File: rtl/dreq_checker.sv
module dreq_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sem_req,
    input logic [SEL_W-1:0] sem_sel,
    input logic             sem_gnt,
    input logic             dma_start,
    input logic [1:0]       dma_dir,
    input logic             db_we,
    input logic [3:0]       db_be,
    input logic             rsp_we,
    input logic             done
);
    assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    assert_single_action_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sem_req, dma_start, db_we, done}));

    assert_sem_hold_R4: assert property (@(posedge clk) disable iff (rst)
        sem_req && !sem_gnt |=> sem_req && $stable(sem_sel));

    assert_legal_start_R5: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> (dma_dir == 2'd1 || dma_dir == 2'd2));

    assert_bell_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        db_we |-> ($countones(db_be) == 1 || $countones(db_be) == 2 || $countones(db_be) == 4));

    assert_rsp_in_done_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_we |-> done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready && !done);
endmodule

bind dma_req_seq dreq_checker #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sem_req   (sem_req),
    .sem_sel   (sem_sel),
    .sem_gnt   (sem_gnt),
    .dma_start (dma_start),
    .dma_dir   (dma_dir),
    .db_we     (db_we),
    .db_be     (db_be),
    .rsp_we    (rsp_we),
    .done      (done)
);

// File: tb/dma_req_seq_tb.sv
module dma_req_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;
    localparam int NP = 4;
    localparam int SW = $clog2(NP + 1);

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready;
    logic [15:0] d_req_id = 0;
    logic [7:0] d_seq_id = 0, d_cmd = 0, d_bell_attr = 0;
    logic [AW-1:0] d_src = 0, d_dst = 0, d_bell_addr = 0;
    logic [31:0] d_len = 0, d_bell_data = 0;
    logic d_pre_en = 0;
    logic [NP-1:0] d_post_en = 0;
    logic sem_req, sem_gnt = 0;
    logic [SW-1:0] sem_sel;
    logic dma_start, dma_bulk, dma_done = 0;
    logic [1:0] dma_dir;
    logic [AW-1:0] dma_src, dma_dst, db_addr;
    logic [31:0] dma_len, db_wdata;
    logic db_we, rsp_we, done, done_irq;
    logic [3:0] db_be;
    logic [15:0] rsp_id, rsp_code;

    int errors = 0, checks = 0, cycles = 0;

    dma_req_seq #(.ADDR_W(AW), .NPOST(NP)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] ev [0:15];
    int nev = 0;
    bit fin_seen = 0;
    int dcnt = 0;
    logic [1:0] g_dir; logic g_bulk; logic [31:0] g_len; logic [AW-1:0] g_src;
    logic [3:0] g_be; logic [31:0] g_data; logic [AW-1:0] g_addr;
    logic g_rsp_we, g_irq; logic [15:0] g_rid, g_code;

    always @(negedge clk) begin
        cycles++;
        dma_done <= 1'b0;
        if (dcnt != 0) begin
            dcnt = dcnt - 1;
            if (dcnt == 0) dma_done <= 1'b1;
        end
        if (sem_req && !sem_gnt) begin
            sem_gnt <= 1'b1;
            if (nev < 16) ev[nev] = 8'h10 + 8'(sem_sel);
            nev++;
        end else sem_gnt <= 1'b0;
        if (dma_start) begin
            if (nev < 16) ev[nev] = 8'h20;
            nev++;
            g_dir = dma_dir; g_bulk = dma_bulk; g_len = dma_len; g_src = dma_src;
            dcnt = 3;
        end
        if (db_we) begin
            if (nev < 16) ev[nev] = 8'h30;
            nev++;
            g_be = db_be; g_data = db_wdata; g_addr = db_addr;
        end
        if (done) begin
            if (nev < 16) ev[nev] = 8'h40;
            nev++;
            g_rsp_we = rsp_we; g_irq = done_irq; g_rid = rsp_id; g_code = rsp_code;
            fin_seen = 1;
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_desc(input logic [1:0] t, input bit ben, input logic [1:0] w,
                            input logic [1:0] lo, input int idx);
        logic [7:0] cmd, attr, xev [0:15];
        logic [15:0] xcode;
        logic [31:0] bd, xd;
        logic [3:0] xbe;
        logic pre;
        logic [NP-1:0] post;
        int xn, wait_n;
        bit seq_ok;
        cmd  = {idx[0], idx[2:1], idx[3] | (t == 2'd3), idx[4], idx[5], t};
        attr = {ben, 5'(idx * 3), w};
        pre  = idx[1];
        post = NP'(idx[4:1] ^ idx[7:4]);
        bd   = 32'hA1B2_C3D4 ^ 32'(idx * 32'h0101_0101);
        // expected completion code (R8)
        if (t == 2'd3) xcode = 16'd1;
        else if (ben && w == 2'd3) xcode = 16'd2;
        else if (ben && ((w == 2'd0 && lo != 0) || (w == 2'd1 && lo[0]))) xcode = 16'd3;
        else xcode = 16'd0;
        xn = 0;
        if (xcode == 0) begin
            if (pre) begin xev[xn] = 8'h10; xn++; end
            if (t != 0) begin xev[xn] = 8'h20; xn++; end
            for (int k = 0; k < NP; k++)
                if (post[k]) begin xev[xn] = 8'h10 + 8'(k + 1); xn++; end
            if (ben) begin xev[xn] = 8'h30; xn++; end
        end
        xev[xn] = 8'h40; xn++;
        case (w)
            2'd0: begin xbe = 4'hF; xd = bd; end
            2'd1: begin xbe = 4'h3 << (2 * lo[1]); xd = {bd[15:0], bd[15:0]}; end
            default: begin xbe = 4'h1 << lo; xd = {4{bd[7:0]}}; end
        endcase

        @(negedge clk); #1;
        nev = 0; fin_seen = 0;
        req_valid = 1; d_req_id = 16'(16'h5000 + idx); d_seq_id = 8'(idx * 7);
        d_cmd = cmd; d_src = 64'h1000_0000_0000 + 64'(idx); d_dst = 64'hD000 + 64'(idx);
        d_len = 32'hFFFF_FF00 + 32'(idx); d_bell_addr = 64'hBE11_0000 + 64'(idx << 2) + 64'(lo);
        d_bell_attr = attr; d_bell_data = bd; d_pre_en = pre; d_post_en = post;
        @(negedge clk); #1;
        // scramble inputs while busy, keep req_valid high (R1)
        d_req_id = 16'hDEAD; d_cmd = 8'hFF; d_bell_attr = 8'h83; d_pre_en = 1; d_post_en = '1;
        d_len = 0; d_src = 0; d_bell_data = 0; d_bell_addr = 1;
        check(!req_ready, "R1 busy after accept", 64'(req_ready), 64'd0);
        wait_n = 0;
        while (!fin_seen && wait_n < 300) begin
            @(negedge clk); #1; wait_n++;
        end
        req_valid = 0;
        check(fin_seen, "R10 done reached", 64'(fin_seen), 64'd1);
        seq_ok = (nev == xn);
        for (int k = 0; k < xn && k < 16; k++) if (ev[k] != xev[k]) seq_ok = 0;
        check(seq_ok, "R3/R4/R8 action order", 64'(nev), 64'(xn));
        check(g_irq == cmd[7], "R10 done_irq", 64'(g_irq), 64'(cmd[7]));
        check(g_rsp_we == cmd[4], "R9 rsp_we", 64'(g_rsp_we), 64'(cmd[4]));
        if (cmd[4]) begin
            check(g_rid == 16'(16'h5000 + idx), "R9 rsp_id", 64'(g_rid), 64'(16'h5000 + idx));
            check(g_code == xcode, "R8 completion code", 64'(g_code), 64'(xcode));
        end
        if (xcode == 0 && t != 0) begin
            check(g_dir == t && g_bulk == cmd[3], "R2 dir/bulk", 64'({g_dir, g_bulk}), 64'({t, cmd[3]}));
            check(g_len == 32'hFFFF_FF00 + 32'(idx) && g_src == 64'h1000_0000_0000 + 64'(idx),
                  "R5 transfer fields", 64'(g_len), 64'(32'hFFFF_FF00 + 32'(idx)));
        end
        if (xcode == 0 && ben) begin
            check(g_be == xbe, "R7 byte strobes", 64'(g_be), 64'(xbe));
            check(g_data == xd, "R7 doorbell data", 64'(g_data), 64'(xd));
            check(g_addr[1:0] == lo, "R6 doorbell address", 64'(g_addr), 64'(lo));
        end
        @(negedge clk); #1;
        check(req_ready, "R1 idle after done", 64'(req_ready), 64'd1);
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        check(req_ready && !sem_req && !dma_start && !db_we && !done,
              "R1 reset state", 64'({req_ready, sem_req, dma_start, db_we, done}), 64'h10);
        idx = 0;
        for (int t = 0; t < 4; t++)
            for (int b = 0; b < 2; b++)
                for (int w = 0; w < 4; w++)
                    for (int lo = 0; lo < 4; lo++) begin
                        run_desc(2'(t), b[0], 2'(w), 2'(lo), idx);
                        idx++;
                    end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule